// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block switches a set of independent power domains on and off under software control. Each domain owns a small bank of 32-bit registers reached through a plain memory-mapped write/read port. The bank holds a wait-mode word, a power-up delay word and a power-down delay word. Software starts a sequence by writing a command. While the domain's sequencer runs, software reads busy status. When the sequence finishes, the status shows the new on/off state and a sticky completion flag.

Every domain drives three control pins: isolation enable, reset assert and power-switch enable. The sequencer changes them one at a time in a fixed safe order. Each step waits for a programmable number of clock cycles taken from the delay word. One chosen domain can also shut itself down without software. When a shared enable bit is set, its processor's wait-for-interrupt signal starts a power-down sequence while the domain is on and idle.

Top module: `power_domain_sequencer`

## Requirements
- R1: After reset every domain reads status 0x0002_0000 (state off, idle, completion flag clear). Its pins are isolation=1, reset=1 and power=0. All delay, wait-mode and auto-enable registers read 0.
- R2: The bank of domain d starts at byte address 0x80*d. Within it, wait-mode sits at 0x14, power-down delay at 0x18, power-up delay at 0x1C, command at 0x20 and status at 0x24; the three delay/mode words read back as written. Offset 0x2C of bank 0 holds the auto power-down enable in bit 0.
- R3: Command value 1 (bits [1:0] at 0x20) to an idle, off domain starts power-up. The write edge t raises power. Reset drops at t+c0+1 and isolation drops at t+c0+c1+2. Busy clears, the state becomes on and the flag sets at t+c0+c1+c2+3. Here c0, c1 and c2 are the power-up word's bytes [7:0], [15:8] and [23:16].
- R4: Command value 2 to an idle, on domain starts power-down. The steps are isolation on at t, reset on at t+c0+1 and power off at t+c0+c1+2, with completion at t+c0+c1+c2+3. The counts come from the power-down word.
- R5: Status bits [17:16] read 1 when the domain is on and 2 when off. While a sequence runs they keep the old state, and bit 3 reads 1 while the sequencer is busy.
- R6: Status bit 1 is set on the completion edge and cleared by writing 1 to bit 1 of the status register.
- R7: The command register always reads back 0 because an accepted command clears itself.
- R8: A command asking for the state the domain already holds sets the completion flag on the write edge and leaves the pins unchanged.
- R9: Command values 0 and 3 change neither pins nor status.
- R10: A command written while the domain is busy is dropped: the running sequence keeps its timing and final state.
- R11: The auto domain (ID 0 by default) starts power-down one edge after auto-enable is 1 while wait-for-interrupt is high, the domain is on and it is idle. With auto-enable 0 it stays on.
- R12: A command to one domain never moves another domain's pins.
- R13: Reset asserted implies isolation asserted, and power off implies reset asserted, at every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrite | input | 1 | Write strobe, sampled on the rising edge |
| busAddr | input | ADDR_W | Byte address for writes and reads |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data for busAddr, combinational |
| cpuWfi | input | 1 | Wait-for-interrupt from the auto domain's processor |
| isoEn | output | NUM_DOM | Isolation enable per domain |
| rstAssert | output | NUM_DOM | Reset assert per domain |
| pwrEn | output | NUM_DOM | Power switch enable per domain |

## Verification
The write edge t is the edge at which busWrite is sampled. Every pin step is due at a fixed edge that follows from t and the three delay bytes: t, t+c0+1, t+c0+c1+2, and completion at t+c0+c1+c2+3. An echoed command sets the flag at t itself, and an auto power-down begins one edge after its trigger is seen. The driver computes these edges when it issues a command and queues the pin values expected at each one, plus the cycle just before each change. The monitor pops each entry at the falling edge that follows its due edge. Status reads are timed to the last busy cycle and to the first cycle after completion, so an off-by-one in any wait shows up as a mismatch.

// File: rtl/pds_pkg.sv
package pds_pkg;
  localparam int REG_W = 32;

  localparam logic [6:0] OFS_WAIT   = 7'h14;
  localparam logic [6:0] OFS_DNDLY  = 7'h18;
  localparam logic [6:0] OFS_UPDLY  = 7'h1C;
  localparam logic [6:0] OFS_CMD    = 7'h20;
  localparam logic [6:0] OFS_STAT   = 7'h24;
  localparam logic [6:0] OFS_AUTO   = 7'h2C;

  localparam logic [1:0] CMD_UP   = 2'd1;
  localparam logic [1:0] CMD_DOWN = 2'd2;
  localparam logic [1:0] ST_ON    = 2'd1;
  localparam logic [1:0] ST_OFF   = 2'd2;

  typedef enum logic [1:0] {PH_IDLE, PH_STEP0, PH_STEP1, PH_STEP2} phase_e;

  typedef struct packed {
    logic       cmdWr;
    logic [1:0] cmdCode;
  } cmdStrobe_t;
endpackage

// File: rtl/pds_regs.sv
module pds_regs
  import pds_pkg::*;
#(
  parameter int NUM_DOM = 3,
  parameter int ADDR_W  = 12,
  parameter int CNT_W   = 8,
  localparam int BANK_W = ADDR_W - 7,
  localparam int DLY_W  = 3 * CNT_W
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            busWrite,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic [REG_W-1:0]                busWData,
  output logic [REG_W-1:0]                busRData,
  input  logic [NUM_DOM-1:0]              doneStb,
  input  logic [NUM_DOM-1:0]              busy,
  input  logic [NUM_DOM-1:0]              isOn,
  output cmdStrobe_t [NUM_DOM-1:0]        cmdStb,
  output logic [NUM_DOM-1:0][DLY_W-1:0]   upDly,
  output logic [NUM_DOM-1:0][DLY_W-1:0]   dnDly,
  output logic                            autoEnable
);
  logic [BANK_W-1:0] bankIdx;
  logic [6:0]        ofs;
  logic [REG_W-1:0]  rdVec [NUM_DOM];
  logic              autoReg;

  assign bankIdx = busAddr[ADDR_W-1:7];
  assign ofs     = busAddr[6:0];

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_bank
    logic             hit;
    logic [REG_W-1:0] waitReg, upReg, dnReg;
    logic             doneFlag;

    assign hit = busWrite && (bankIdx == BANK_W'(d));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        waitReg <= '0;
        upReg   <= '0;
        dnReg   <= '0;
      end else if (hit) begin
        if (ofs == OFS_WAIT)  waitReg <= busWData;
        if (ofs == OFS_UPDLY) upReg   <= busWData;
        if (ofs == OFS_DNDLY) dnReg   <= busWData;
      end
    end

    // completion flag: set on done, write-one clears, set wins
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                    doneFlag <= 1'b0;
      else if (doneStb[d])                          doneFlag <= 1'b1;
      else if (hit && ofs == OFS_STAT && busWData[1]) doneFlag <= 1'b0;
    end

    assign cmdStb[d].cmdWr   = hit && (ofs == OFS_CMD);
    assign cmdStb[d].cmdCode = busWData[1:0];
    assign upDly[d] = upReg[DLY_W-1:0];
    assign dnDly[d] = dnReg[DLY_W-1:0];

    always_comb begin
      rdVec[d] = '0;
      case (ofs)
        OFS_WAIT:  rdVec[d] = waitReg;
        OFS_UPDLY: rdVec[d] = upReg;
        OFS_DNDLY: rdVec[d] = dnReg;
        OFS_STAT:  rdVec[d] = {14'b0, (isOn[d] ? ST_ON : ST_OFF), 12'b0,
                               busy[d], 1'b0, doneFlag, 1'b0};
        OFS_AUTO:  rdVec[d] = (d == 0) ? {31'b0, autoReg} : '0;
        default:   rdVec[d] = '0;
      endcase
    end

    // R6: a done strobe always leaves the flag set
    p_flag_after_done_r6: assert property (@(posedge clk) disable iff (!rstN)
      doneStb[d] |=> doneFlag);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) autoReg <= 1'b0;
    else if (busWrite && bankIdx == '0 && ofs == OFS_AUTO) autoReg <= busWData[0];
  end
  assign autoEnable = autoReg;

  always_comb begin
    busRData = '0;
    for (int d = 0; d < NUM_DOM; d++)
      if (bankIdx == BANK_W'(d)) busRData = rdVec[d];
  end
endmodule

// File: rtl/pds_seq.sv
module pds_seq
  import pds_pkg::*;
#(
  parameter int NUM_DOM  = 3,
  parameter int CNT_W    = 8,
  parameter int AUTO_DOM = 0,
  localparam int DLY_W   = 3 * CNT_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  cmdStrobe_t [NUM_DOM-1:0]      cmdStb,
  input  logic [NUM_DOM-1:0][DLY_W-1:0] upDly,
  input  logic [NUM_DOM-1:0][DLY_W-1:0] dnDly,
  input  logic                          autoEnable,
  input  logic                          cpuWfi,
  output logic [NUM_DOM-1:0]            doneStb,
  output logic [NUM_DOM-1:0]            busy,
  output logic [NUM_DOM-1:0]            isOn,
  output logic [NUM_DOM-1:0]            isoEn,
  output logic [NUM_DOM-1:0]            rstAssert,
  output logic [NUM_DOM-1:0]            pwrEn
);
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             onReg, goingUp, isoR, rstR, pwrR;
    logic             idle, wantUp, wantDown, autoTrig, startUp, startDown;
    logic             echo, lastStep;
    logic [DLY_W-1:0] runDly;

    assign idle     = (phase == PH_IDLE);
    assign autoTrig = (d == AUTO_DOM) && autoEnable && cpuWfi && !cmdStb[d].cmdWr;
    assign wantUp   = cmdStb[d].cmdWr && cmdStb[d].cmdCode == CMD_UP;
    assign wantDown = (cmdStb[d].cmdWr && cmdStb[d].cmdCode == CMD_DOWN) || (autoTrig && onReg);
    assign startUp   = idle && wantUp && !onReg;
    assign startDown = idle && wantDown && onReg;
    assign echo      = idle && ((wantUp && onReg) || (wantDown && !onReg));
    assign lastStep  = (phase == PH_STEP2) && (cnt == '0);
    assign runDly    = goingUp ? upDly[d] : dnDly[d];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        phase   <= PH_IDLE;
        cnt     <= '0;
        onReg   <= 1'b0;
        goingUp <= 1'b0;
        isoR    <= 1'b1;
        rstR    <= 1'b1;
        pwrR    <= 1'b0;
      end else begin
        case (phase)
          PH_IDLE: begin
            if (startUp) begin
              pwrR    <= 1'b1;
              cnt     <= upDly[d][0 +: CNT_W];
              goingUp <= 1'b1;
              phase   <= PH_STEP0;
            end else if (startDown) begin
              isoR    <= 1'b1;
              cnt     <= dnDly[d][0 +: CNT_W];
              goingUp <= 1'b0;
              phase   <= PH_STEP0;
            end
          end
          PH_STEP0: begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            else begin
              rstR  <= !goingUp;
              cnt   <= runDly[CNT_W +: CNT_W];
              phase <= PH_STEP1;
            end
          end
          PH_STEP1: begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            else begin
              if (goingUp) isoR <= 1'b0;
              else         pwrR <= 1'b0;
              cnt   <= runDly[2*CNT_W +: CNT_W];
              phase <= PH_STEP2;
            end
          end
          default: begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            else begin
              onReg <= goingUp;
              phase <= PH_IDLE;
            end
          end
        endcase
      end
    end

    assign doneStb[d]   = lastStep || echo;
    assign busy[d]      = !idle;
    assign isOn[d]      = onReg;
    assign isoEn[d]     = isoR;
    assign rstAssert[d] = rstR;
    assign pwrEn[d]     = pwrR;

    // R13: safe ordering of the three pins
    p_reset_needs_iso_r13: assert property (@(posedge clk) disable iff (!rstN)
      rstR |-> isoR);
    p_unpowered_in_reset_r13: assert property (@(posedge clk) disable iff (!rstN)
      !pwrR |-> rstR);
    // R5: at rest the pins agree with the reported state
    p_idle_pins_match_r5: assert property (@(posedge clk) disable iff (!rstN)
      idle |-> (onReg ? (pwrR && !isoR && !rstR) : (!pwrR && isoR && rstR)));
    // R10: a write during a sequence does not change its direction
    p_busy_write_dropped_r10: assert property (@(posedge clk) disable iff (!rstN)
      (!idle && cmdStb[d].cmdWr) |=> (goingUp == $past(goingUp)));
    // R11: without a command or an auto trigger an idle domain stays idle
    p_no_spontaneous_start_r11: assert property (@(posedge clk) disable iff (!rstN)
      (idle && !cmdStb[d].cmdWr && !autoTrig) |=> (phase == PH_IDLE));
  end
endmodule

// File: rtl/power_domain_sequencer.sv
module power_domain_sequencer
  import pds_pkg::*;
#(
  parameter int NUM_DOM  = 3,
  parameter int ADDR_W   = 12,
  parameter int CNT_W    = 8,
  parameter int AUTO_DOM = 0,
  localparam int DLY_W   = 3 * CNT_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWData,
  output logic [31:0]        busRData,
  input  logic               cpuWfi,
  output logic [NUM_DOM-1:0] isoEn,
  output logic [NUM_DOM-1:0] rstAssert,
  output logic [NUM_DOM-1:0] pwrEn
);
  cmdStrobe_t [NUM_DOM-1:0]        cmdStb;
  logic [NUM_DOM-1:0][DLY_W-1:0]   upDly, dnDly;
  logic [NUM_DOM-1:0]              doneStb, busy, isOn;
  logic                            autoEnable;

  pds_regs #(.NUM_DOM(NUM_DOM), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_regs (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .doneStb(doneStb), .busy(busy),
    .isOn(isOn), .cmdStb(cmdStb), .upDly(upDly), .dnDly(dnDly),
    .autoEnable(autoEnable));

  pds_seq #(.NUM_DOM(NUM_DOM), .CNT_W(CNT_W), .AUTO_DOM(AUTO_DOM)) i_seq (
    .clk(clk), .rstN(rstN), .cmdStb(cmdStb), .upDly(upDly), .dnDly(dnDly),
    .autoEnable(autoEnable), .cpuWfi(cpuWfi), .doneStb(doneStb), .busy(busy),
    .isOn(isOn), .isoEn(isoEn), .rstAssert(rstAssert), .pwrEn(pwrEn));
endmodule

// File: tb/test_power_domain_sequencer.sv
module test_power_domain_sequencer;
  localparam int N = 3;
  localparam logic [31:0] ST_OFF_IDLE = 32'h0002_0000;
  localparam logic [31:0] ST_ON_IDLE  = 32'h0001_0000;

  logic clk = 1'b0, rstN = 1'b0, busWrite = 1'b0, cpuWfi = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWData = '0, busRData;
  logic [N-1:0] isoEn, rstAssert, pwrEn;
  int cyc = 0, checks = 0, fails = 0;

  power_domain_sequencer i_power_domain_sequencer (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .cpuWfi(cpuWfi),
    .isoEn(isoEn), .rstAssert(rstAssert), .pwrEn(pwrEn));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {int due; int dom; logic [2:0] pins; string tag;} item_t;
  item_t q[$];

  function automatic logic [11:0] ad(int d, logic [6:0] o);
    return 12'(d * 128) + 12'(o);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(int due, int dom, logic [2:0] pins, string tag);
    item_t it;
    int i = 0;
    it.due = due; it.dom = dom; it.pins = pins; it.tag = tag;
    while (i < q.size() && q[i].due <= due) i++;
    q.insert(i, it);
  endtask

  // monitor: pins {iso,rst,pwr} compared at the falling edge after their due edge
  always @(negedge clk) begin
    #1;
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      if (it.due < cyc) chk({it.tag, " late"}, 32'(cyc), 32'(it.due));
      else chk(it.tag, {29'b0, isoEn[it.dom], rstAssert[it.dom], pwrEn[it.dom]},
               {29'b0, it.pins});
      for (int d = 0; d < N; d++)
        chk("R13", {30'b0, rstAssert[d] && !isoEn[d], !pwrEn[d] && !rstAssert[d]}, 32'b0);
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] v, output int t);
    @(negedge clk);
    busWrite = 1'b1; busAddr = a; busWData = v;
    t = cyc + 1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    busAddr = a;
    #2 v = busRData;
  endtask

  task automatic waitCyc(int x);
    while (cyc < x) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int t;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int d = 0; d < N; d++) begin
      rd(ad(d, 7'h24), v); chk("R1 status", v, ST_OFF_IDLE);
      chk("R1 pins", {29'b0, isoEn[d], rstAssert[d], pwrEn[d]}, 32'h6);
      rd(ad(d, 7'h1C), v); chk("R1 updly", v, 0);
      rd(ad(d, 7'h14), v); chk("R1 wait", v, 0);
    end
    rd(ad(0, 7'h2C), v); chk("R1 auto", v, 0);

    // R2 map and readback
    wr(ad(1, 7'h14), 32'h8, t);
    wr(ad(1, 7'h18), 32'h0008_0808, t);
    wr(ad(2, 7'h1C), 32'hA5A5_A5A5, t);
    rd(ad(1, 7'h14), v); chk("R2 wait", v, 32'h8);
    rd(ad(1, 7'h18), v); chk("R2 dndly", v, 32'h0008_0808);
    rd(ad(2, 7'h1C), v); chk("R2 updly", v, 32'hA5A5_A5A5);
    rd(ad(0, 7'h1C), v); chk("R2 stride", v, 0);
    wr(ad(0, 7'h2C), 32'hFFFF_FFFF, t);
    rd(ad(0, 7'h2C), v); chk("R2 auto", v, 1);
    wr(ad(0, 7'h2C), 32'h0, t);
    wr(ad(1, 7'h18), 32'h0, t);
    wr(ad(2, 7'h1C), 32'h0, t);

    // R3 power-up of domain 0 with c0=1 c1=2 c2=3
    wr(ad(0, 7'h1C), 32'h0003_0201, t);
    wr(ad(0, 7'h20), 32'h1, t);
    push(t, 0, 3'b111, "R3 step1");   push(t + 1, 0, 3'b111, "R3 hold1");
    push(t + 2, 0, 3'b101, "R3 step2"); push(t + 4, 0, 3'b101, "R3 hold2");
    push(t + 5, 0, 3'b001, "R3 step3");
    push(t, 1, 3'b110, "R12 dom1");   push(t, 2, 3'b110, "R12 dom2");
    rd(ad(0, 7'h24), v); chk("R5 busy", v, 32'h0002_0008);
    waitCyc(t + 7); rd(ad(0, 7'h24), v); chk("R3 last busy", v, 32'h0002_0008);
    rd(ad(0, 7'h24), v); chk("R3 done", v, 32'h0001_0002);
    rd(ad(0, 7'h20), v); chk("R7 cmd reads 0", v, 0);

    // R6 write-one-to-clear
    wr(ad(0, 7'h24), 32'h2, t);
    rd(ad(0, 7'h24), v); chk("R6 clear", v, ST_ON_IDLE);

    // R8 echo command
    wr(ad(0, 7'h20), 32'h1, t);
    push(t, 0, 3'b001, "R8 pins");
    rd(ad(0, 7'h24), v); chk("R8 flag", v, 32'h0001_0002);
    wr(ad(0, 7'h24), 32'h2, t);

    // R9 codes 3 and 0
    wr(ad(0, 7'h20), 32'h3, t);
    push(t, 0, 3'b001, "R9 code3 pins");
    rd(ad(0, 7'h24), v); chk("R9 code3 status", v, ST_ON_IDLE);
    wr(ad(0, 7'h20), 32'h0, t);
    push(t, 0, 3'b001, "R9 code0 pins");
    rd(ad(0, 7'h24), v); chk("R9 code0 status", v, ST_ON_IDLE);

    // R10 busy write dropped, domain 1 zero delays
    wr(ad(1, 7'h20), 32'h1, t);
    push(t, 1, 3'b111, "R10 step1"); push(t + 1, 1, 3'b101, "R10 step2");
    push(t + 2, 1, 3'b001, "R10 step3"); push(t + 2, 2, 3'b110, "R12 dom2 still");
    wr(ad(1, 7'h20), 32'h2, t);
    rd(ad(1, 7'h24), v); chk("R10 final", v, 32'h0001_0002);
    push(cyc + 3, 1, 3'b001, "R10 stays on");

    // R4 power-down of domain 0 with c0=c1=c2=1
    wr(ad(0, 7'h18), 32'h0001_0101, t);
    wr(ad(0, 7'h20), 32'h2, t);
    push(t, 0, 3'b101, "R4 step1");     push(t + 1, 0, 3'b101, "R4 hold1");
    push(t + 2, 0, 3'b111, "R4 step2"); push(t + 3, 0, 3'b111, "R4 hold2");
    push(t + 4, 0, 3'b110, "R4 step3");
    waitCyc(t + 4); rd(ad(0, 7'h24), v); chk("R4 last busy", v, 32'h0001_0008);
    rd(ad(0, 7'h24), v); chk("R4 done", v, 32'h0002_0002);
    wr(ad(0, 7'h24), 32'h2, t);

    // R11 auto power-down
    wr(ad(0, 7'h20), 32'h1, t);
    waitCyc(t + 10);
    cpuWfi = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 disabled pins", {29'b0, isoEn[0], rstAssert[0], pwrEn[0]}, 32'h1);
    rd(ad(0, 7'h24), v); chk("R11 disabled status", v, 32'h0001_0002);
    wr(ad(0, 7'h24), 32'h2, t);
    wr(ad(0, 7'h2C), 32'h1, t);
    push(t, 0, 3'b001, "R11 before");   push(t + 1, 0, 3'b101, "R11 step1");
    push(t + 3, 0, 3'b111, "R11 step2"); push(t + 5, 0, 3'b110, "R11 step3");
    waitCyc(t + 6); rd(ad(0, 7'h24), v); chk("R11 done", v, 32'h0002_0002);
    cpuWfi = 1'b0;

    waitCyc(cyc + 4);
    while (q.size() > 0) @(negedge clk);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule